// File: doc/BRIEF.md
# Serial Audio Sample Receiver

This block takes a three-wire serial audio stream (bit clock, frame clock and data) and turns it into parallel stereo samples for a playback path. It runs entirely in the local system clock domain. The three serial lines are passed through a synchronizer, and the active bit clock edge is detected as a one-cycle pulse. Because of this, the bit clock may stop between bits and the two half-frames may differ in length. Four framing conventions are supported: left justified, delayed-by-one-bit (I2S), right justified, and a pulse-framed format in which both words follow a single sync pulse. The word length is selectable.

Every captured word is scaled to a 24-bit two's-complement sample. Shorter words gain zero LSBs and longer words lose their surplus LSBs. The two samples of a stereo pair are presented together on a single valid strobe. Two independent controls are available. One routes each channel to the opposite output. The other declares that the pair arrives right channel first, so the pair is released only after the left word completes. A standby input silences the output and discards any partly captured data.

Top module: `dac_serial_rx`

## Requirements
- R1: With `fmt_sel`=0 (left justified), the word's MSB is the bit taken at the first capture edge after the frame clock changes level, and a frame clock high means the left channel.
- R2: With `fmt_sel`=1 (I2S), the MSB is taken one capture edge later than in R1, and a frame clock low means the left channel. A 32-bit word in a 32-bit half-frame still completes: its LSB arrives at the same capture edge that starts the next half-frame.
- R3: With `fmt_sel`=2 (right justified), the word is the last N bits captured before the frame clock changes level, and a frame clock high means the left channel.
- R4: With `fmt_sel`=3 (pulse framed), a frame clock seen high at one capture edge after being low marks a frame. The first slot's MSB is taken at the next capture edge, and the second slot follows immediately after the first.
- R5: Bits are captured on the rising edge of `bclk_in` when `bclk_inv`=0 and on the falling edge when `bclk_inv`=1.
- R6: `wlen_sel` codes 0/1/2/3 select 16/20/24/32-bit words. A 16-bit word becomes sample bits [23:8] and a 20-bit word becomes bits [23:4], with the lower bits set to zero.
- R7: For 32-bit words, the upper 24 bits form the sample and the 8 LSBs are discarded.
- R8: In the formats of R1, R2 and R4, bits that arrive after N bits of a half-frame or slot have been taken do not affect the samples.
- R9: With `chan_swap`=1, the left-channel word appears on `smp_right` and the right-channel word on `smp_left`.
- R10: With `pair_rl`=0, a pair is released after its right word, and the left word that precedes it is held. With `pair_rl`=1, a pair is released after its left word, and the right word that precedes it is held. In pulse-framed mode, `pair_rl`=1 assigns the first slot to the right channel.
- R11: Each pair drives `smp_valid` high for exactly one cycle, which follows completion of the pair's second word. `smp_left` and `smp_right` keep their values while `smp_valid` is low.
- R12: Capture is correct when the bit clock pauses between bits and when the two half-frames have different lengths.
- R13: While `standby` is high, `smp_valid` stays low. Any partly captured data and any held first word are discarded.
- R14: After reset, `smp_valid`, `smp_left` and `smp_right` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Silences output and clears capture state |
| fmt_sel | input | 2 | Framing: 0 left justified, 1 I2S, 2 right justified, 3 pulse framed |
| wlen_sel | input | 2 | Word length: 0=16, 1=20, 2=24, 3=32 bits |
| bclk_inv | input | 1 | 1 selects the falling bit clock edge for capture |
| chan_swap | input | 1 | Exchanges the output channels |
| pair_rl | input | 1 | Pair arrives right channel first |
| bclk_in | input | 1 | Serial bit clock |
| lrck_in | input | 1 | Serial frame clock |
| sdata_in | input | 1 | Serial data |
| smp_valid | output | 1 | One-cycle strobe for a completed pair |
| smp_left | output | SAMPLE_W | Left output sample |
| smp_right | output | SAMPLE_W | Right output sample |

## Verification
Two events can fall on the same capture edge: the completion of one word and the start of the next half-frame. This happens in I2S mode when a 32-bit word fills a 32-bit half-frame, because its LSB arrives at the edge where the frame clock has already changed. The bench drives exactly that framing with the right-first pair order, so a released pair depends on that shared edge for the LSB of both words. A separate case drops standby between a held first word and its partner. There, the result is judged by the absence of a pair that combines data from before and after standby.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

   typedef enum logic [1:0] {
      FMT_LJ  = 2'd0,
      FMT_I2S = 2'd1,
      FMT_RJ  = 2'd2,
      FMT_DSP = 2'd3
   } fmt_e;

   // word length in bits for a length code
   function automatic int unsigned wl_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 16;
         2'd1:    return 20;
         2'd2:    return 24;
         default: return 32;
      endcase
   endfunction

endpackage

// File: rtl/dsr_sync_edge.sv
module dsr_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inv,
   input  logic bclk,
   input  logic lrck,
   input  logic sdat,
   output logic cap,
   output logic lrc_s,
   output logic dat_s
);
   localparam int LINES = 3;

   logic [LINES-1:0] raw;
   logic             eff;
   logic             eff_q;

   if (STAGES == 0) begin : g_direct
      assign raw = {bclk, lrck, sdat};
   end else begin : g_sync
      logic [LINES*STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[LINES*(STAGES-1)-1:0], bclk, lrck, sdat};
      end
      assign raw = chain[LINES*STAGES-1 -: LINES];
   end

   assign eff = raw[2] ^ inv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eff_q <= 1'b1;
      else        eff_q <= eff;
   end

   assign cap   = eff & ~eff_q;
   assign lrc_s = raw[1];
   assign dat_s = raw[0];

endmodule

// File: rtl/dsr_deser.sv
module dsr_deser
   import dsr_pkg::*;
#(
   parameter int SLOT_MAX = 32,
   parameter int CNT_W    = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                standby,
   input  logic                cap,
   input  logic                lrc,
   input  logic                dat,
   input  logic [1:0]          fmt,
   input  logic [CNT_W-1:0]    wl,
   input  logic                pair_rl,
   output logic                word_stb,
   output logic [SLOT_MAX-1:0] word_raw,
   output logic                word_left
);
   localparam logic [1:0] SLOT_IDLE = 2'd2;

   fmt_e                fmt_q;
   logic [SLOT_MAX-1:0] sreg, sreg_n, sh, acc;
   logic [CNT_W-1:0]    cnt, cnt_n, accn;
   logic                lrc_q, lrc_n, synced, sync_n;
   logic [1:0]          slot, slot_n;
   logic                close, close_left;
   logic [SLOT_MAX-1:0] close_val;
   logic                trans, room;

   assign fmt_q = fmt_e'(fmt);
   assign sh    = {sreg[SLOT_MAX-2:0], dat};
   assign trans = lrc ^ lrc_q;
   assign room  = cnt < wl;
   assign acc   = room ? sh : sreg;
   assign accn  = room ? cnt + 1'b1 : cnt;

   always_comb begin
      sreg_n     = sreg;
      cnt_n      = cnt;
      lrc_n      = lrc_q;
      sync_n     = synced;
      slot_n     = slot;
      close      = 1'b0;
      close_val  = sreg;
      close_left = 1'b0;
      if (cap) begin
         lrc_n = lrc;
         case (fmt_q)
            FMT_LJ: begin
               if (trans) begin
                  close      = synced && (cnt >= wl);
                  close_left = lrc_q;
                  sreg_n     = {{(SLOT_MAX-1){1'b0}}, dat};
                  cnt_n      = CNT_W'(1);
                  sync_n     = 1'b1;
               end else if (room) begin
                  sreg_n = sh;
                  cnt_n  = cnt + 1'b1;
               end
            end
            FMT_I2S: begin
               if (trans) begin
                  close      = synced && (accn >= wl);
                  close_val  = acc;
                  close_left = ~lrc_q;
                  sreg_n     = '0;
                  cnt_n      = '0;
                  sync_n     = 1'b1;
               end else begin
                  sreg_n = acc;
                  cnt_n  = accn;
               end
            end
            FMT_RJ: begin
               if (trans) begin
                  close      = synced && (cnt >= wl);
                  close_left = lrc_q;
                  sreg_n     = {{(SLOT_MAX-1){1'b0}}, dat};
                  cnt_n      = CNT_W'(1);
                  sync_n     = 1'b1;
               end else begin
                  sreg_n = sh;
                  cnt_n  = (&cnt) ? cnt : cnt + 1'b1;
               end
            end
            FMT_DSP: begin
               if (lrc && !lrc_q) begin
                  sreg_n = '0;
                  cnt_n  = '0;
                  slot_n = 2'd0;
                  sync_n = 1'b1;
               end else if (synced && slot < SLOT_IDLE) begin
                  if (cnt + 1'b1 == wl) begin
                     close      = 1'b1;
                     close_val  = sh;
                     close_left = (slot == 2'd0) ^ pair_rl;
                     sreg_n     = '0;
                     cnt_n      = '0;
                     slot_n     = slot + 2'd1;
                  end else begin
                     sreg_n = sh;
                     cnt_n  = cnt + 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg      <= '0;
         cnt       <= '0;
         lrc_q     <= 1'b0;
         synced    <= 1'b0;
         slot      <= SLOT_IDLE;
         word_stb  <= 1'b0;
         word_raw  <= '0;
         word_left <= 1'b0;
      end else if (standby) begin
         sreg      <= '0;
         cnt       <= '0;
         lrc_q     <= 1'b0;
         synced    <= 1'b0;
         slot      <= SLOT_IDLE;
         word_stb  <= 1'b0;
         word_raw  <= '0;
         word_left <= 1'b0;
      end else begin
         sreg     <= sreg_n;
         cnt      <= cnt_n;
         lrc_q    <= lrc_n;
         synced   <= sync_n;
         slot     <= slot_n;
         word_stb <= close;
         if (close) begin
            word_raw  <= close_val;
            word_left <= close_left;
         end
      end
   end

endmodule

// File: rtl/dsr_norm.sv
module dsr_norm #(
   parameter int SLOT_MAX = 32,
   parameter int SAMPLE_W = 24,
   parameter int CNT_W    = 6
) (
   input  logic [SLOT_MAX-1:0] raw,
   input  logic [CNT_W-1:0]    wl,
   output logic [SAMPLE_W-1:0] sample
);
   localparam int WIDE_W = SLOT_MAX + SAMPLE_W;

   logic [SLOT_MAX-1:0] masked;
   logic [WIDE_W-1:0]   wide;

   // keep only the word's own bits, then place its MSB at the sample MSB
   assign masked = raw & ~({SLOT_MAX{1'b1}} << wl);
   assign wide   = {masked, {SAMPLE_W{1'b0}}} >> wl;
   assign sample = SAMPLE_W'(wide);

endmodule

// File: rtl/dsr_pair.sv
module dsr_pair #(
   parameter int SAMPLE_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                standby,
   input  logic                word_stb,
   input  logic [SAMPLE_W-1:0] word_val,
   input  logic                word_left,
   input  logic                pair_rl,
   input  logic                chan_swap,
   output logic                valid,
   output logic [SAMPLE_W-1:0] left,
   output logic [SAMPLE_W-1:0] right
);
   logic                is_first;
   logic                have_first;
   logic [SAMPLE_W-1:0] held;
   logic [SAMPLE_W-1:0] in_l, in_r;

   assign is_first = (word_left != pair_rl);
   assign in_l     = word_left ? word_val : held;
   assign in_r     = word_left ? held : word_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_first <= 1'b0;
         held       <= '0;
         valid      <= 1'b0;
         left       <= '0;
         right      <= '0;
      end else if (standby) begin
         have_first <= 1'b0;
         held       <= '0;
         valid      <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (word_stb) begin
            if (is_first) begin
               held       <= word_val;
               have_first <= 1'b1;
            end else if (have_first) begin
               have_first <= 1'b0;
               valid      <= 1'b1;
               left       <= chan_swap ? in_r : in_l;
               right      <= chan_swap ? in_l : in_r;
            end
         end
      end
   end

endmodule

// File: rtl/dac_serial_rx.sv
module dac_serial_rx #(
   parameter int SYNC_STAGES = 2,
   parameter int SLOT_MAX    = 32,
   parameter int SAMPLE_W    = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                standby,
   input  logic [1:0]          fmt_sel,
   input  logic [1:0]          wlen_sel,
   input  logic                bclk_inv,
   input  logic                chan_swap,
   input  logic                pair_rl,
   input  logic                bclk_in,
   input  logic                lrck_in,
   input  logic                sdata_in,
   output logic                smp_valid,
   output logic [SAMPLE_W-1:0] smp_left,
   output logic [SAMPLE_W-1:0] smp_right
);
   localparam int CNT_W = $clog2(SLOT_MAX) + 1;

   if (SLOT_MAX < 32) begin : g_bad_slot
      $error("SLOT_MAX must hold a 32-bit word");
   end
   if (SAMPLE_W < 8 || SAMPLE_W > SLOT_MAX) begin : g_bad_sample
      $error("SAMPLE_W out of range");
   end
   if (SYNC_STAGES == 1) begin : g_bad_sync
      $error("SYNC_STAGES must be 0 or at least 2");
   end

   logic                cap, lrc_s, dat_s;
   logic [CNT_W-1:0]    wl;
   logic                w_stb, w_left;
   logic [SLOT_MAX-1:0] w_raw;
   logic [SAMPLE_W-1:0] w_val;

   assign wl = CNT_W'(dsr_pkg::wl_bits(wlen_sel));

   dsr_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .inv   (bclk_inv),
      .bclk  (bclk_in),
      .lrck  (lrck_in),
      .sdat  (sdata_in),
      .cap   (cap),
      .lrc_s (lrc_s),
      .dat_s (dat_s)
   );

   dsr_deser #(.SLOT_MAX(SLOT_MAX), .CNT_W(CNT_W)) u_deser (
      .clk       (clk),
      .rst_n     (rst_n),
      .standby   (standby),
      .cap       (cap),
      .lrc       (lrc_s),
      .dat       (dat_s),
      .fmt       (fmt_sel),
      .wl        (wl),
      .pair_rl   (pair_rl),
      .word_stb  (w_stb),
      .word_raw  (w_raw),
      .word_left (w_left)
   );

   dsr_norm #(.SLOT_MAX(SLOT_MAX), .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_norm (
      .raw    (w_raw),
      .wl     (wl),
      .sample (w_val)
   );

   dsr_pair #(.SAMPLE_W(SAMPLE_W)) u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .standby   (standby),
      .word_stb  (w_stb),
      .word_val  (w_val),
      .word_left (w_left),
      .pair_rl   (pair_rl),
      .chan_swap (chan_swap),
      .valid     (smp_valid),
      .left      (smp_left),
      .right     (smp_right)
   );

endmodule

// File: rtl/dac_serial_rx_chk.sv
module dac_serial_rx_chk #(
   parameter int SAMPLE_W = 24
) (
   input logic                clk,
   input logic                rst_n,
   input logic                standby,
   input logic [1:0]          wlen_sel,
   input logic                word_stb,
   input logic                smp_valid,
   input logic [SAMPLE_W-1:0] smp_left,
   input logic [SAMPLE_W-1:0] smp_right
);

   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> !smp_valid);                                             // R11

   AST_PAIR_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> $past(word_stb));                                        // R11

   AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |-> ($stable(smp_left) && $stable(smp_right)));             // R11

   AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> !smp_valid);                                               // R13

   AST_PAD_16: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && wlen_sel == 2'd0) |-> (smp_left[7:0] == 8'h00 && smp_right[7:0] == 8'h00)); // R6

   AST_PAD_20: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && wlen_sel == 2'd1) |-> (smp_left[3:0] == 4'h0 && smp_right[3:0] == 4'h0));   // R6

endmodule

bind dac_serial_rx dac_serial_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .standby   (standby),
   .wlen_sel  (wlen_sel),
   .word_stb  (w_stb),
   .smp_valid (smp_valid),
   .smp_left  (smp_left),
   .smp_right (smp_right)
);

// File: tb/dac_serial_rx_test.sv
module dac_serial_rx_test;
   localparam int CLK_P  = 10;
   localparam int HALF   = 4 * CLK_P;
   localparam int WD_CYC = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        standby = 1'b0;
   logic [1:0]  fmt_sel = 2'd0;
   logic [1:0]  wlen_sel = 2'd0;
   logic        bclk_inv = 1'b0;
   logic        chan_swap = 1'b0;
   logic        pair_rl = 1'b0;
   logic        bclk_in = 1'b1;
   logic        lrck_in = 1'b0;
   logic        sdata_in = 1'b0;
   logic        smp_valid;
   logic [23:0] smp_left, smp_right;

   int          checks = 0;
   int          errors = 0;
   logic [23:0] q_l[$];
   logic [23:0] q_r[$];
   string       q_tag[$];
   logic        i2s_prev = 1'b0;
   bit          gapped = 1'b0;
   int          gap_n = 0;

   dac_serial_rx uut (
      .clk(clk), .rst_n(rst_n), .standby(standby),
      .fmt_sel(fmt_sel), .wlen_sel(wlen_sel), .bclk_inv(bclk_inv),
      .chan_swap(chan_swap), .pair_rl(pair_rl),
      .bclk_in(bclk_in), .lrck_in(lrck_in), .sdata_in(sdata_in),
      .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right)
   );

   always #(CLK_P/2) clk = ~clk;

   function automatic int wl_of(input logic [1:0] c);
      return (c == 2'd3) ? 32 : 16 + 4 * int'(c);
   endfunction

   function automatic logic [23:0] norm(input logic [31:0] w, input int wl);
      case (wl)
         16:      return {w[15:0], 8'h00};
         20:      return {w[19:0], 4'h0};
         24:      return w[23:0];
         default: return w[31:8];
      endcase
   endfunction

   // scoreboard driver side: expected pair from the true left/right words
   task automatic push(input logic [31:0] lw, input logic [31:0] rw, input string tag);
      logic [23:0] nl, nr;
      nl = norm(lw, wl_of(wlen_sel));
      nr = norm(rw, wl_of(wlen_sel));
      if (chan_swap) begin q_l.push_back(nr); q_r.push_back(nl); end
      else           begin q_l.push_back(nl); q_r.push_back(nr); end
      q_tag.push_back(tag);
   endtask

   // one bit period: launch on the non-capture edge, capture edge mid-bit
   task automatic bit_out(input logic lv, input logic d);
      logic dd;
      if (fmt_sel == 2'd1) begin dd = i2s_prev; i2s_prev = d; end
      else dd = d;
      bclk_in = bclk_inv; lrck_in = lv; sdata_in = dd;
      #(HALF);
      bclk_in = ~bclk_inv;
      #(HALF);
      if (gapped) begin
         gap_n++;
         if (gap_n % 5 == 0) #(3 * HALF);
      end
   endtask

   task automatic half(input logic lv, input logic [31:0] w, input int slots);
      int wl;
      wl = wl_of(wlen_sel);
      for (int k = 0; k < slots; k++) begin
         logic d;
         if (fmt_sel == 2'd2) d = (k < slots - wl) ? 1'b1 : w[slots-1-k];
         else                 d = (k < wl) ? w[wl-1-k] : 1'b1;
         bit_out(lv, d);
      end
   endtask

   task automatic stereo2(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                          input logic [31:0] d, input int sa, input int sb, input string tag);
      logic lvl_left, lvl_first;
      lvl_left  = (fmt_sel == 2'd1) ? 1'b0 : 1'b1;
      lvl_first = pair_rl ? ~lvl_left : lvl_left;
      if (!pair_rl) begin push(a, b, tag); push(c, d, tag); end
      else          begin push(b, a, tag); push(d, c, tag); end
      half(~lvl_first, 32'h0, 2);
      half(lvl_first, a, sa);
      half(~lvl_first, b, sb);
      half(lvl_first, c, sa);
      half(~lvl_first, d, sb);
      half(lvl_first, 32'h0, 2);
   endtask

   task automatic dsp_frame(input logic [31:0] a, input logic [31:0] b, input string tag);
      int wl;
      wl = wl_of(wlen_sel);
      if (!pair_rl) push(a, b, tag); else push(b, a, tag);
      bit_out(1'b1, 1'b1);
      for (int k = 0; k < wl; k++) bit_out(1'b0, a[wl-1-k]);
      for (int k = 0; k < wl; k++) bit_out(1'b0, b[wl-1-k]);
      for (int k = 0; k < 6; k++) bit_out(1'b0, 1'b1);
   endtask

   task automatic setup(input logic [1:0] f, input logic [1:0] w, input logic inv,
                        input logic sw, input logic rl);
      standby = 1'b1;
      repeat (4) @(posedge clk);
      fmt_sel = f; wlen_sel = w; bclk_inv = inv; chan_swap = sw; pair_rl = rl;
      bclk_in = ~inv; lrck_in = 1'b0; sdata_in = 1'b0; i2s_prev = 1'b0;
      repeat (6) @(posedge clk);
      standby = 1'b0;
      repeat (4) @(posedge clk);
   endtask

   task automatic drain(input string tag);
      repeat (40) @(posedge clk);
      checks++;
      if (q_l.size() != 0) begin
         errors++;
         $display("FAIL %s: %0d pairs still pending, expected 0", tag, q_l.size());
         q_l.delete(); q_r.delete(); q_tag.delete();
      end
   endtask

   // scoreboard monitor side
   always @(negedge clk) begin
      if (rst_n && smp_valid) begin
         checks++;
         if (q_l.size() == 0) begin
            errors++;
            $display("FAIL R13 R11: unexpected pair L=%h R=%h, expected none", smp_left, smp_right);
         end else begin
            logic [23:0] el, er;
            string t;
            el = q_l.pop_front();
            er = q_r.pop_front();
            t  = q_tag.pop_front();
            if (smp_left !== el || smp_right !== er) begin
               errors++;
               $display("FAIL %s: got L=%h R=%h expected L=%h R=%h", t, smp_left, smp_right, el, er);
            end
         end
      end
   end

   initial begin
      #(WD_CYC * CLK_P);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (smp_valid !== 1'b0 || smp_left !== 24'h0 || smp_right !== 24'h0) begin
         errors++;
         $display("FAIL R14: valid=%b L=%h R=%h expected 0 0 0", smp_valid, smp_left, smp_right);
      end
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      checks++;
      if (smp_valid !== 1'b0 || smp_left !== 24'h0 || smp_right !== 24'h0) begin
         errors++;
         $display("FAIL R14: after release valid=%b L=%h R=%h expected 0 0 0", smp_valid, smp_left, smp_right);
      end

      // left justified, 16-bit words in 32-bit half-frames, filler ones after the word
      setup(2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
      stereo2(32'h0000_A5C3, 32'h0000_1F7E, 32'h0000_8001, 32'h0000_7FFE, 32, 32, "R1 R6 R8 left-justified 16-bit");
      drain("R11 left-justified 16-bit");

      // I2S, 24-bit, inverted bit clock
      setup(2'd1, 2'd2, 1'b1, 1'b0, 1'b0);
      stereo2(32'h00C0_FFEE, 32'h0012_3456, 32'h0080_0001, 32'h007F_FF00, 32, 32, "R2 R5 R8 i2s 24-bit inverted clock");
      drain("R11 i2s 24-bit");

      // right justified, 20-bit, unequal half-frames, pausing bit clock
      setup(2'd2, 2'd1, 1'b0, 1'b0, 1'b0);
      gapped = 1'b1;
      stereo2(32'h000A_BCDE, 32'h0008_0F01, 32'h0001_2345, 32'h000F_FFF0, 32, 24, "R3 R6 R12 right-justified 20-bit gapped");
      gapped = 1'b0;
      drain("R11 R12 right-justified");

      // left justified, 32-bit, channel swap
      setup(2'd0, 2'd3, 1'b0, 1'b1, 1'b0);
      stereo2(32'hDEAD_BEEF, 32'h1357_9BDF, 32'h8000_00FF, 32'h7654_3210, 32, 32, "R7 R9 left-justified 32-bit swapped");
      drain("R11 R9 swap");

      // I2S 32-bit in full 32-bit half-frames, right channel first
      setup(2'd1, 2'd3, 1'b0, 1'b0, 1'b1);
      stereo2(32'hF0E1_D2C3, 32'h0A1B_2C3D, 32'h8765_4321, 32'h0000_01FF, 32, 32, "R2 R7 R10 i2s 32-bit right-first");
      drain("R10 i2s right-first");

      // pulse framed, 16-bit, then 24-bit right-first with swap
      setup(2'd3, 2'd0, 1'b0, 1'b0, 1'b0);
      dsp_frame(32'h0000_9ABC, 32'h0000_4321, "R4 R6 R8 pulse framed 16-bit");
      dsp_frame(32'h0000_FFFF, 32'h0000_0001, "R4 R6 pulse framed 16-bit");
      drain("R11 pulse framed");
      setup(2'd3, 2'd2, 1'b0, 1'b1, 1'b1);
      dsp_frame(32'h00AB_CDEF, 32'h0055_AA11, "R4 R9 R10 pulse framed 24-bit");
      drain("R10 pulse framed right-first");

      // standby: held first word discarded, nothing released while in standby
      setup(2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
      half(1'b0, 32'h0, 2);
      half(1'b1, 32'h0000_1111, 32);
      half(1'b0, 32'h0000_2222, 3);
      standby = 1'b1;
      half(1'b1, 32'h0000_3333, 32);
      half(1'b0, 32'h0000_4444, 32);
      half(1'b1, 32'h0000_5555, 32);
      standby = 1'b0;
      repeat (4) @(posedge clk);
      push(32'h0000_6666, 32'h0000_7777, "R13 after standby");
      half(1'b1, 32'h0, 2);
      half(1'b0, 32'h0000_2222, 32);
      half(1'b1, 32'h0000_6666, 32);
      half(1'b0, 32'h0000_7777, 32);
      half(1'b1, 32'h0, 2);
      drain("R13 standby");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule